// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a slow byte-wide CPU bus a small four-byte window through which it reaches a register file that lives in a separate controller clock domain. The CPU starts a target read or target write with a single-cycle strobe carrying the target address (and, for writes, the data byte). The bridge latches the request, passes it across the clock boundary with a toggle handshake, and shows progress through three flags in a status byte. Returned read data is captured into a data byte the CPU fetches afterwards.

Only one target transfer may be outstanding. New target strobes that arrive while a transfer is in flight are dropped, so software polls the status byte before issuing the next access. Besides the window, the block presents a PHY status byte built from five live PHY inputs. Software can replace it with a byte of its own by writing a non-zero source-select enable.

Both window bytes that software writes (enable and value) are plain storage. The status byte and the read-data byte are read-only. All CPU-side logic runs on `cpuClk`; the target-side request and capture logic runs on `ctrlClk`.

Top module: `iab_top`

## Requirements
- R1: The window decodes `winAddr` as 0 = status, 1 = read data, 2 = source-select enable, 3 = source-select value, and `winRdata` shows the addressed byte combinationally. Writes to offsets 2 and 3 store the whole byte. Writes to offsets 0 and 1 change nothing. Status bits 7:3 read 0.
- R2: Status bit 0 (read done) sets on the CPU clock edge where a target read completes. It clears on the edge where the next target read is accepted.
- R3: Status bit 1 (fresh data unread) sets when a target read completes and clears on a CPU read of offset 1 (`winRd` high with `winAddr` = 1). If both happen on the same edge, the set wins.
- R4: Status bit 2 (write busy) is high from the edge a target write is accepted until the edge its completion returns to the CPU side.
- R5: A target strobe (`tgtRd` or `tgtWr`) is accepted only when no transfer is outstanding. Strobes arriving while one is outstanding, including on the completion edge itself, are ignored. When `tgtRd` and `tgtWr` are both high, the access is a write.
- R6: With the source-select enable equal to zero, `phyStat` is {3'b000, host-disconnect, ID pin, session-end, A-session-valid, VBUS-valid}, VBUS-valid in bit 0.
- R7: With the source-select enable non-zero, `phyStat` equals the stored source-select value, and the live PHY inputs have no effect on it.
- R8: During reset, status, read data, source-select enable and value are all 0x00, and `regReq` is low.
- R9: Each accepted transfer produces exactly one single-cycle `regReq` pulse in the controller domain, carrying the accepted address, the write flag and the write byte.
- R10: After a target read completes, offset 1 holds the `regRdata` byte that accompanied `regAck` for that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | CPU-side clock |
| cpuRstN | input | 1 | CPU-side active-low asynchronous reset |
| winRd | input | 1 | Window read strobe (offset 1 read clears the unread flag) |
| winWr | input | 1 | Window write strobe |
| winAddr | input | 2 | Window byte offset |
| cpuWdata | input | 8 | CPU write byte for window writes and target writes |
| winRdata | output | 8 | Addressed window byte |
| tgtRd | input | 1 | Start a target read |
| tgtWr | input | 1 | Start a target write |
| tgtAddr | input | ADDR_W | Target register address |
| phyVbusValid | input | 1 | PHY VBUS-valid level |
| phyAValid | input | 1 | PHY A-session-valid level |
| phySessEnd | input | 1 | PHY session-end level |
| phyIdDig | input | 1 | PHY ID pin level |
| phyHostDisc | input | 1 | PHY host-disconnect level |
| phyStat | output | 8 | PHY status byte (live or overridden) |
| ctrlClk | input | 1 | Controller-side clock |
| ctrlRstN | input | 1 | Controller-side active-low asynchronous reset |
| regReq | output | 1 | Single-cycle request to the register file |
| regWe | output | 1 | Request is a write |
| regAddr | output | ADDR_W | Register address of the request |
| regWdata | output | 8 | Write byte of the request |
| regAck | input | 1 | Register file completion pulse |
| regRdata | input | 8 | Read byte, valid with `regAck` |

## Verification
The two pairs of functions that meet on one edge are a read completion with a CPU fetch of the data byte, and a completion with a fresh target strobe. The bench keeps the data-byte read asserted through a whole read transfer, and in another run holds a target read strobe high across several transfers. Its behavioural model then expects the unread flag to be set after the colliding edge and the held strobe to be taken only on the edge after completion. Every status, data and PHY byte is compared against that model on each clock.

// File: rtl/iab_pkg.sv
`timescale 1ns/1ps
package iab_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] OFS_STAT  = 2'd0;
  localparam logic [1:0] OFS_RDATA = 2'd1;
  localparam logic [1:0] OFS_SEN   = 2'd2;
  localparam logic [1:0] OFS_SVAL  = 2'd3;

  typedef struct packed {
    logic loadReq;
    logic capRd;
    logic setSrcEn;
    logic setSrcVal;
  } iabStb_t;
endpackage

// File: rtl/iab_tgl_sync.sv
`timescale 1ns/1ps
module iab_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/iab_cpu_ctl.sv
`timescale 1ns/1ps
module iab_cpu_ctl
  import iab_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              winRd,
  input  logic              winWr,
  input  logic [1:0]        winAddr,
  input  logic              tgtRd,
  input  logic              tgtWr,
  input  logic              ackTgl,
  output logic              reqTgl,
  output iabStb_t           stb,
  output logic [BYTE_W-1:0] statByte
);
  logic inFlight, kindWr, readOk, unread, ackSync, ackPrev;
  logic ackSeen, accept, rdDone, dataFetch;

  iab_tgl_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk (clk),
    .rstN(rstN),
    .d   (ackTgl),
    .q   (ackSync)
  );

  assign ackSeen   = (ackSync ^ ackPrev) & inFlight;
  assign accept    = (tgtRd | tgtWr) & ~inFlight;
  assign rdDone    = ackSeen & ~kindWr;
  assign dataFetch = winRd & (winAddr == OFS_RDATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev  <= 1'b0;
      inFlight <= 1'b0;
      kindWr   <= 1'b0;
      reqTgl   <= 1'b0;
      readOk   <= 1'b0;
      unread   <= 1'b0;
    end else begin
      ackPrev <= ackSync;
      if (accept) begin
        inFlight <= 1'b1;
        kindWr   <= tgtWr;
        reqTgl   <= ~reqTgl;
        if (!tgtWr) readOk <= 1'b0;
      end else if (ackSeen) begin
        inFlight <= 1'b0;
        if (!kindWr) readOk <= 1'b1;
      end
      if (rdDone)         unread <= 1'b1;
      else if (dataFetch) unread <= 1'b0;
    end
  end

  always_comb begin
    stb.loadReq   = accept;
    stb.capRd     = rdDone;
    stb.setSrcEn  = winWr & (winAddr == OFS_SEN);
    stb.setSrcVal = winWr & (winAddr == OFS_SVAL);
  end

  assign statByte = {5'b00000, inFlight & kindWr, unread, readOk};

  AST_REQ_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |=> $stable(reqTgl)); // R5
  AST_RDOK_FROM_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readOk) |-> $past(ackSync ^ ackPrev)); // R2
  AST_UNREAD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (dataFetch && !rdDone) |=> !unread); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (statByte[2] && !(ackSync ^ ackPrev)) |=> statByte[2]); // R4
endmodule

// File: rtl/iab_cpu_dp.sv
`timescale 1ns/1ps
module iab_cpu_dp
  import iab_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  iabStb_t           stb,
  input  logic [1:0]        winAddr,
  input  logic [BYTE_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              tgtWr,
  input  logic [BYTE_W-1:0] statByte,
  input  logic [BYTE_W-1:0] ctrlRdHold,
  input  logic [4:0]        phyLive,
  output logic [BYTE_W-1:0] winRdata,
  output logic [BYTE_W-1:0] phyStat,
  output logic [ADDR_W-1:0] addrHold,
  output logic [BYTE_W-1:0] wdataHold,
  output logic              weHold
);
  logic [BYTE_W-1:0] readData, srcEn, srcVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold  <= '0;
      wdataHold <= '0;
      weHold    <= 1'b0;
      readData  <= '0;
      srcEn     <= '0;
      srcVal    <= '0;
    end else begin
      if (stb.loadReq) begin
        addrHold  <= tgtAddr;
        wdataHold <= cpuWdata;
        weHold    <= tgtWr;
      end
      if (stb.capRd)     readData <= ctrlRdHold;
      if (stb.setSrcEn)  srcEn    <= cpuWdata;
      if (stb.setSrcVal) srcVal   <= cpuWdata;
    end
  end

  always_comb begin
    unique case (winAddr)
      OFS_STAT:  winRdata = statByte;
      OFS_RDATA: winRdata = readData;
      OFS_SEN:   winRdata = srcEn;
      default:   winRdata = srcVal;
    endcase
  end

  assign phyStat = (srcEn != '0) ? srcVal : {3'b000, phyLive};
endmodule

// File: rtl/iab_reg_side.sv
`timescale 1ns/1ps
module iab_reg_side
  import iab_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqTgl,
  input  logic              regAck,
  input  logic [BYTE_W-1:0] regRdata,
  output logic              regReq,
  output logic              ackTgl,
  output logic [BYTE_W-1:0] rdHold
);
  logic reqSync, reqPrev, awaitAck;

  iab_tgl_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk (clk),
    .rstN(rstN),
    .d   (reqTgl),
    .q   (reqSync)
  );

  assign regReq = reqSync ^ reqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev  <= 1'b0;
      awaitAck <= 1'b0;
      ackTgl   <= 1'b0;
      rdHold   <= '0;
    end else begin
      reqPrev <= reqSync;
      if (regReq) begin
        awaitAck <= 1'b1;
      end else if (awaitAck && regAck) begin
        awaitAck <= 1'b0;
        ackTgl   <= ~ackTgl;
        rdHold   <= regRdata;
      end
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regReq |=> !regReq); // R9
  AST_ACK_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (!awaitAck) |=> $stable(ackTgl)); // R9
endmodule

// File: rtl/iab_top.sv
`timescale 1ns/1ps
module iab_top
  import iab_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic              winRd,
  input  logic              winWr,
  input  logic [1:0]        winAddr,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        winRdata,
  input  logic              tgtRd,
  input  logic              tgtWr,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              phyVbusValid,
  input  logic              phyAValid,
  input  logic              phySessEnd,
  input  logic              phyIdDig,
  input  logic              phyHostDisc,
  output logic [7:0]        phyStat,
  input  logic              ctrlClk,
  input  logic              ctrlRstN,
  output logic              regReq,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWdata,
  input  logic              regAck,
  input  logic [7:0]        regRdata
);
  iabStb_t           stb;
  logic              reqTgl, ackTgl;
  logic [BYTE_W-1:0] statByte, rdHold;
  logic [4:0]        phyLive;

  assign phyLive = {phyHostDisc, phyIdDig, phySessEnd, phyAValid, phyVbusValid};

  iab_cpu_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk     (cpuClk),
    .rstN    (cpuRstN),
    .winRd   (winRd),
    .winWr   (winWr),
    .winAddr (winAddr),
    .tgtRd   (tgtRd),
    .tgtWr   (tgtWr),
    .ackTgl  (ackTgl),
    .reqTgl  (reqTgl),
    .stb     (stb),
    .statByte(statByte)
  );

  iab_cpu_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (cpuClk),
    .rstN      (cpuRstN),
    .stb       (stb),
    .winAddr   (winAddr),
    .cpuWdata  (cpuWdata),
    .tgtAddr   (tgtAddr),
    .tgtWr     (tgtWr),
    .statByte  (statByte),
    .ctrlRdHold(rdHold),
    .phyLive   (phyLive),
    .winRdata  (winRdata),
    .phyStat   (phyStat),
    .addrHold  (regAddr),
    .wdataHold (regWdata),
    .weHold    (regWe)
  );

  iab_reg_side #(.SYNC_STAGES(SYNC_STAGES)) u_side (
    .clk     (ctrlClk),
    .rstN    (ctrlRstN),
    .reqTgl  (reqTgl),
    .regAck  (regAck),
    .regRdata(regRdata),
    .regReq  (regReq),
    .ackTgl  (ackTgl),
    .rdHold  (rdHold)
  );
endmodule

// File: tb/iab_top_bench.sv
`timescale 1ns/1ps
module iab_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic winRd = 0, winWr = 0, tgtRd = 0, tgtWr = 0;
  logic [1:0] winAddr = 0;
  logic [7:0] cpuWdata = 0, tgtAddr = 0;
  logic pV = 0, pA = 0, pS = 0, pI = 0, pH = 0;
  logic [7:0] winRdata, phyStat, regAddr, regWdata;
  logic regReq, regWe;
  logic regAck = 1'b0;
  logic [7:0] regRdata = 8'h00;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iab_top u_iab_top (
    .cpuClk(clk), .cpuRstN(rstN), .winRd(winRd), .winWr(winWr),
    .winAddr(winAddr), .cpuWdata(cpuWdata), .winRdata(winRdata),
    .tgtRd(tgtRd), .tgtWr(tgtWr), .tgtAddr(tgtAddr),
    .phyVbusValid(pV), .phyAValid(pA), .phySessEnd(pS), .phyIdDig(pI),
    .phyHostDisc(pH), .phyStat(phyStat), .ctrlClk(clk), .ctrlRstN(rstN),
    .regReq(regReq), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck), .regRdata(regRdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // register file behind the bridge
  logic [7:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hC3;

  // behavioural reference model
  int cyc = 0, doneAt = 0, accepts = 0, reqPulses = 0;
  bit mBusy = 0, mKindWr = 0, mReadOk = 0, mUnread = 0;
  logic [7:0] mRd = 0, mEn = 0, mVal = 0, mPend = 0, mPAddr = 0, mPWdata = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; mBusy = 0; mKindWr = 0; mReadOk = 0; mUnread = 0;
      mRd = 0; mEn = 0; mVal = 0;
    end else begin
      bit comp, acc;
      cyc++;
      comp = mBusy && (cyc == doneAt);
      acc  = (tgtRd || tgtWr) && !mBusy;
      if (comp) begin
        mBusy = 0;
        if (!mKindWr) begin mReadOk = 1; mRd = mPend; end
      end
      if (comp && !mKindWr) mUnread = 1;
      else if (winRd && winAddr == 2'd1) mUnread = 0;
      if (acc) begin
        mBusy = 1; mKindWr = tgtWr; doneAt = cyc + 7;
        mPAddr = tgtAddr; mPWdata = cpuWdata; accepts++;
        if (!tgtWr) begin mReadOk = 0; mPend = mem[tgtAddr]; end
      end
      if (winWr && winAddr == 2'd2) mEn = cpuWdata;
      if (winWr && winAddr == 2'd3) mVal = cpuWdata;
    end
  end

  // responder: one-cycle acknowledge
  always @(posedge clk) begin
    regAck <= rstN && regReq;
    if (rstN && regReq) begin
      reqPulses++;
      chk("R9 regAddr", regAddr, mPAddr);
      chk("R9 regWe", {7'd0, regWe}, {7'd0, mKindWr});
      if (regWe) chk("R9 regWdata", regWdata, mPWdata);
      regRdata <= mem[regAddr];
      if (regWe) mem[regAddr] <= regWdata;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [7:0] expPhy;
      case (winAddr)
        2'd0: begin
          chk("R2 readDone", {7'd0, winRdata[0]}, {7'd0, mReadOk});
          chk("R3 unread", {7'd0, winRdata[1]}, {7'd0, mUnread});
          chk("R4 writeBusy", {7'd0, winRdata[2]}, {7'd0, mBusy && mKindWr});
          chk("R1 statusUpper", {3'd0, winRdata[7:3]}, 8'd0);
        end
        2'd1: chk("R10 readData", winRdata, mRd);
        2'd2: chk("R1 srcEnable", winRdata, mEn);
        default: chk("R1 srcValue", winRdata, mVal);
      endcase
      expPhy = (mEn != 0) ? mVal : {3'b000, pH, pI, pS, pA, pV};
      chk((mEn != 0) ? "R7 phyOverride" : "R6 phyLive", phyStat, expPhy);
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(input int n); repeat (n) step(); endtask
  task automatic winWrite(input logic [1:0] a, input logic [7:0] d);
    step(); winWr = 1; winAddr = a; cpuWdata = d;
    step(); winWr = 0; winAddr = 0;
  endtask
  task automatic tgtAccess(input bit wr, input logic [7:0] a, input logic [7:0] d);
    step(); tgtWr = wr; tgtRd = !wr; tgtAddr = a; cpuWdata = d;
    step(); tgtWr = 0; tgtRd = 0;
  endtask
  task automatic fetchData();
    step(); winRd = 1; winAddr = 1;
    step(); winRd = 0; winAddr = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    // R8: reset values
    for (int a = 0; a < 4; a++) begin
      @(posedge clk); #1 winAddr = 2'(a);
      @(negedge clk);
      chk("R8 resetByte", winRdata, 8'h00);
      chk("R8 resetReq", {7'd0, regReq}, 8'h00);
    end
    step(); winAddr = 0; rstN = 1;

    // R6: live PHY bits
    idle(2); pV = 1; idle(2); pA = 1; pI = 1; idle(2);
    pV = 0; pS = 1; pH = 1; idle(2);
    // R1: status and data bytes are not writable
    winWrite(2'd0, 8'hFF); winWrite(2'd1, 8'hFF);
    step(); winAddr = 1; step(); winAddr = 0;
    // R7: override
    winWrite(2'd3, 8'hA5); idle(2);
    winWrite(2'd2, 8'h01); idle(2);
    pV = 1; pS = 0; pH = 0; idle(2);
    step(); winAddr = 2; step(); winAddr = 3; step(); winAddr = 0;
    winWrite(2'd2, 8'h00); idle(2);

    // R4/R5: target write, reads during busy are dropped
    step(); tgtWr = 1; tgtAddr = 8'h10; cpuWdata = 8'h3C;
    step(); tgtWr = 0; tgtRd = 1; tgtAddr = 8'h11;
    idle(3); tgtRd = 0; idle(8);

    // R2/R3/R10: target read then fetch
    tgtAccess(0, 8'h10, 8'h00); idle(10);
    fetchData(); idle(2);

    // R3 collision: fetch held through the completion edge
    tgtAccess(1, 8'h20, 8'h5A); idle(9);
    step(); tgtRd = 1; tgtAddr = 8'h20; winRd = 1; winAddr = 1;
    step(); tgtRd = 0; idle(8);
    winRd = 0; winAddr = 0; idle(2);
    fetchData(); idle(2);

    // R5: strobe held across completions
    step(); tgtRd = 1; tgtAddr = 8'h42;
    idle(4); tgtAddr = 8'h43; idle(10); tgtAddr = 8'h44; idle(8);
    tgtRd = 0; idle(10);

    // R5: both strobes -> write
    step(); tgtRd = 1; tgtWr = 1; tgtAddr = 8'h30; cpuWdata = 8'h77;
    step(); tgtRd = 0; tgtWr = 0; idle(10);
    tgtAccess(0, 8'h30, 8'h00); idle(10);
    step(); winAddr = 1; step(); winAddr = 0; idle(4);

    checks++;
    if (accepts != reqPulses) begin
      fails++;
      $display("FAIL R9 pulses actual=%0d expected=%0d", reqPulses, accepts);
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule